// File: doc/BRIEF.md
# Frame-Based Sawtooth PWM Generator

This block drives one output pin with a free-running sawtooth pulse-width modulated waveform. A clock divider turns the system clock into base ticks. A frame counter steps on each tick from 1 up to a programmable frame length and then starts the next frame. The output is high for every tick whose counter value does not exceed the duty value in use, so each frame begins with a high stretch followed by a low stretch.

Software writes a 32-bit configuration word and a 16-bit duty word. The low half of the configuration word sets the tick divider. The high half sets the frame length. The duty word is sampled only when a frame begins and is held until that frame ends. Because of this, a duty write in the middle of a frame cannot glitch the pin. A one-clock frame-start pulse tells software that the next duty write will apply to the frame after the current one. Once enabled, frames repeat without any retriggering.

As an example, a 160 MHz clock with a divider of 48 and a frame length of 65535 ticks gives frames of about 19.66 ms.

Top module: `sawpwm_top`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `pwm_out` and `frame_start` are low.
- R2: `cfg[15:0]` gives the number of system clocks per base tick. A value of 0 acts as 1.
- R3: `cfg[31:16]` gives the frame length N in ticks. With divider P, every frame lasts exactly P*N clocks, and frames repeat for as long as `en` stays high.
- R4: `duty[15:0]` is captured when a frame starts and held for that whole frame. A write made mid-frame only affects the following frame.
- R5: Within a frame, the output is high on ticks whose counter value (1..N) is at most the captured duty. For duty d ≤ N this gives P*d high clocks per frame, and they start at the frame's first clock.
- R6: A captured duty of 0 keeps the output low for the whole frame. A captured duty of N or more keeps it high for the whole frame.
- R7: `frame_start` is high for exactly the first clock of each frame (N*P > 1).
- R8: While `en` is low, the divider and frame counter are cleared and both outputs are low from the next clock on. After `en` rises, the first frame starts at the first tick, which is P clocks later.
- R9: A duty write that lands in the last clock of a frame is captured for the next frame. A write in the first clock of a frame waits one more frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears and idles the generator |
| cfg | input | 32 | [15:0] clocks per tick, [31:16] frame length in ticks |
| duty | input | 16 | Duty value, sampled at each frame start |
| pwm_out | output | 1 | Registered PWM output |
| frame_start | output | 1 | One-clock pulse on the first clock of each frame |

## Verification
A software duty write and the frame wrap that samples the duty can fall in the same clock. This is where a latch-at-boundary design is most fragile. The bench synchronises on `frame_start` and counts the frame's clocks. It then changes the duty exactly in the last clock before the wrap, and later exactly in the first clock after it. It judges each case by counting the high clocks of the next two whole frames against P times the duty that should have been captured.

// File: rtl/sawpwm_pkg.sv
package sawpwm_pkg;
  localparam int PRESC_W_DEF = 16;
  localparam int CNT_W_DEF   = 16;

  typedef enum logic {
    RAMP_IDLE = 1'b0,
    RAMP_RUN  = 1'b1
  } ramp_state_t;
endpackage

// File: rtl/sawpwm_prescaler.sv
module sawpwm_prescaler #(
  parameter int PRESC_W = sawpwm_pkg::PRESC_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);
  logic [PRESC_W-1:0] div_cnt;
  logic [PRESC_W-1:0] div_eff;

  // a divider of zero behaves like one
  assign div_eff = (div == '0) ? PRESC_W'(1) : div;
  assign tick    = en && (div_cnt >= div_eff - PRESC_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en)  div_cnt <= '0;
    else if (tick)   div_cnt <= '0;
    else             div_cnt <= div_cnt + PRESC_W'(1);
  end

  // two ticks in a row only when the divider is one
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && div_eff > PRESC_W'(1) && $stable(div)) |=> !tick);
endmodule

// File: rtl/sawpwm_ramp.sv
module sawpwm_ramp #(
  parameter int CNT_W = sawpwm_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [CNT_W-1:0] nxt_duty,
  output logic             frame_start
);
  import sawpwm_pkg::*;

  ramp_state_t      st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_q;
  logic             wrap;

  assign wrap     = (st == RAMP_IDLE) || (cnt >= period);
  assign nxt_cnt  = wrap ? CNT_W'(1) : cnt + CNT_W'(1);
  assign nxt_duty = wrap ? duty : duty_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st          <= RAMP_IDLE;
      cnt         <= '0;
      duty_q      <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= tick && wrap;
      if (tick) begin
        st     <= RAMP_RUN;
        cnt    <= nxt_cnt;
        duty_q <= nxt_duty;
      end
    end
  end

  // captured duty only moves at a frame boundary or on disable
  assert_duty_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !(tick && wrap)) |=> ($stable(duty_q) || !en));

  // a frame only starts on a tick
  assert_start_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(tick));
endmodule

// File: rtl/sawpwm_compare.sv
module sawpwm_compare #(
  parameter int CNT_W = sawpwm_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic [CNT_W-1:0] nxt_duty,
  output logic             pwm
);
  always_ff @(posedge clk) begin
    if (rst || !en)  pwm <= 1'b0;
    else if (load)   pwm <= (nxt_duty >= nxt_cnt);
  end

  // zero duty can never raise the pin
  assert_zero_low_R6: assert property (@(posedge clk) disable iff (rst)
    (en && load && nxt_duty == '0) |=> !pwm);
endmodule

// File: rtl/sawpwm_top.sv
module sawpwm_top #(
  parameter int PRESC_W = sawpwm_pkg::PRESC_W_DEF,
  parameter int CNT_W   = sawpwm_pkg::CNT_W_DEF,
  localparam int CFG_W  = PRESC_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out,
  output logic             frame_start
);
  logic             tick;
  logic [CNT_W-1:0] nxt_cnt;
  logic [CNT_W-1:0] nxt_duty;

  sawpwm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk (clk), .rst (rst), .en (en),
    .div (cfg[PRESC_W-1:0]),
    .tick(tick)
  );

  sawpwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk        (clk), .rst (rst), .en (en), .tick (tick),
    .period     (cfg[CFG_W-1:PRESC_W]),
    .duty       (duty),
    .nxt_cnt    (nxt_cnt),
    .nxt_duty   (nxt_duty),
    .frame_start(frame_start)
  );

  sawpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk), .rst (rst), .en (en), .load (tick),
    .nxt_cnt (nxt_cnt),
    .nxt_duty(nxt_duty),
    .pwm     (pwm_out)
  );

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && !frame_start));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pwm_out && !frame_start));
endmodule

// File: tb/test_sawpwm_top.sv
module test_sawpwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] cfg = '0;
  logic [15:0] duty = '0;
  logic        pwm_out, frame_start;
  int checks = 0;
  int fails  = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sawpwm_top i_sawpwm_top (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg), .duty(duty),
    .pwm_out(pwm_out), .frame_start(frame_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_frame();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_start && n < 100000);
  endtask

  // starts at a negedge showing frame_start, ends at the next one
  task automatic measure(output int len, output int hi);
    int guard = 0;
    len = 0; hi = 0;
    do begin
      hi += int'(pwm_out);
      len++;
      @(negedge clk);
      guard++;
    end while (!frame_start && guard < 100000);
  endtask

  task automatic setup(input int p, input int n, input int d);
    @(negedge clk);
    en = 1'b0;
    cfg = {n[15:0], p[15:0]};
    duty = d[15:0];
    @(negedge clk);
    en = 1'b1;
    sync_frame();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_out), 0);
    chk("R1 frame_start in reset", int'(frame_start), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pwm after reset", int'(pwm_out), 0);
  endtask

  task automatic t_basic();
    int len, hi;
    setup(1, 10, 4);
    chk("R5 high at frame start", int'(pwm_out), 1);
    measure(len, hi);
    chk("R3 frame length P=1", len, 10);
    chk("R5 high clocks d=4", hi, 4);
    measure(len, hi);
    chk("R3 repeat frame length", len, 10);
    chk("R7 second frame high", hi, 4);
  endtask

  task automatic t_presc();
    int len, hi;
    setup(3, 8, 5);
    measure(len, hi);
    chk("R2 frame length P=3", len, 24);
    chk("R5 high clocks P=3", hi, 15);
    setup(0, 6, 2);
    measure(len, hi);
    chk("R2 divider zero acts as one", len, 6);
    chk("R2 high clocks divider zero", hi, 2);
  endtask

  task automatic t_extremes();
    int len, hi;
    setup(2, 10, 0);
    measure(len, hi);
    chk("R6 zero duty low", hi, 0);
    setup(2, 10, 10);
    measure(len, hi);
    chk("R6 full duty high", hi, len);
    setup(1, 10, 50);
    measure(len, hi);
    chk("R6 oversize duty high", hi, 10);
  endtask

  task automatic t_midframe();
    int hi = 0;
    int len, hi2;
    setup(2, 10, 3);
    for (int i = 0; i < 20; i++) begin
      if (i == 9) duty = 16'd7;
      hi += int'(pwm_out);
      @(negedge clk);
    end
    chk("R7 frame_start after frame", int'(frame_start), 1);
    chk("R4 mid-frame write ignored", hi, 6);
    measure(len, hi2);
    chk("R4 new duty next frame", hi2, 14);
  endtask

  task automatic t_coincide();
    int len, hi;
    setup(1, 8, 2);
    for (int i = 0; i < 7; i++) @(negedge clk);
    duty = 16'd6;
    @(negedge clk);
    chk("R7 wrap pulse", int'(frame_start), 1);
    duty = 16'd1;
    measure(len, hi);
    chk("R9 last-clock write captured", hi, 6);
    measure(len, hi);
    chk("R9 first-clock write deferred", hi, 1);
  endtask

  task automatic t_enable();
    int n = 0;
    setup(1, 10, 10);
    en = 1'b0;
    @(negedge clk);
    chk("R8 pwm off when disabled", int'(pwm_out), 0);
    chk("R8 frame_start off when disabled", int'(frame_start), 0);
    cfg = {16'd4, 16'd3};
    en = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_start && n < 50);
    chk("R8 first frame after P clocks", n, 3);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_presc();
    t_extremes();
    t_midframe();
    t_coincide();
    t_enable();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule